// File: doc/BRIEF.md
# Binary and Decimal Add/Subtract Unit with Legacy Flag Behaviour

This block is the arithmetic core of an 8-bit accumulator datapath. It adds or subtracts a memory operand to or from an accumulator operand, with a carry input. It returns the result together with negative, overflow, zero and carry flags. A decimal-mode input switches the result to packed BCD. In that mode the flags are formed the way older NMOS parts formed them, not the way a clean BCD adder would. The zero flag tracks the plain binary sum. The negative and overflow flags come from the sum before the upper digit is corrected. Digits above nine are not rejected. They are corrected by the same add-six rule, which gives odd but repeatable results.

The datapath is combinational. It is split into a binary adder and a chain of per-digit decimal correction slices. Its outputs are captured in a register on every clock cycle in which `go` is high. A result therefore appears one clock after its operands are presented. The result and flags hold while `go` is low.

Top module: `bcd_addsub_alu`

## Requirements
- R1: With `dec`=0 and `sub`=0, the cycle after `go`, `res` = (A + M + cin) mod 256. `flag_c` is the carry out of bit 7. `flag_n` is bit 7 of `res`. `flag_z` is 1 exactly when `res` is zero. `flag_v` is 1 when A and M have the same sign bit and `res` has the other sign.
- R2: With `dec`=0 and `sub`=1, the unit adds A, the bitwise inverse of M and cin, and sets the flags as in R1. `flag_c` is therefore 1 exactly when A >= M + (1 - cin), so cin acts as not-borrow.
- R3: With `dec`=1 and `sub`=0, each 4-bit digit is formed as digit(A) + digit(M) + incoming carry. Any digit sum of 10 or more has 6 added, keeps its low four bits and passes a carry of 1 to the next digit. This holds for non-decimal digits too. For example, $00+$0F=$15, $00+$1F=$25, $10+$1F=$35, $05+$1F=$2A, $0F+$0A=$1F and $0F+$0B=$10, all with cin=0.
- R4: With `dec`=1 and `sub`=0, `flag_z` is 1 exactly when (A + M + cin) mod 256 is zero, whatever the decimal result. For example, $80+$80 with cin=0 gives `res`=$60, `flag_z`=1 and `flag_c`=1.
- R5: With `dec`=1 and `sub`=0, `flag_n` and `flag_v` are taken from the intermediate value: the corrected low digit plus the uncorrected upper digit sum. `flag_n` is bit 7 of that value, and `flag_v` is its signed-overflow test against A and M. `flag_c` is 1 exactly when the upper digit sum is 10 or more. For example, $50+$50 gives `res`=$00 with N=1, V=1, Z=0 and C=1.
- R6: With `dec`=1 and `sub`=1, each digit is formed as digit(A) - digit(M) - incoming borrow, where the lowest borrow is 1 - cin. A negative digit has 6 subtracted, keeps its low four bits and passes a borrow of 1 to the next digit. All four flags equal those of the binary subtraction of R2.
- R7: Outputs change only on a clock edge at which `go` is 1. While `go` is 0 they hold, whatever the other inputs do.
- R8: While reset is active, and after reset is released, `res` and all four flags read zero until the first capture.
- R9: In decimal add, if every digit of A and M is 0 to 9, every digit of `res` is 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| go | input | 1 | Capture enable for result and flags |
| a | input | 8 | Accumulator operand |
| m | input | 8 | Memory operand |
| cin | input | 1 | Carry in; acts as not-borrow when subtracting |
| dec | input | 1 | 1 selects decimal mode |
| sub | input | 1 | 1 selects subtraction |
| res | output | 8 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |

## Verification
The embedded assertions are checked on every cycle. They cover:
- the hold behaviour while `go` is low;
- the not-borrow carry of every subtraction;
- the zero flag tracking the binary sum in decimal add;
- the zero flag matching the result in binary mode;
- decimal sums of valid digits staying within BCD.

The bench scenarios are the only place the exact decimal values are shown, including the legacy results for digits above nine and the intermediate-derived N and V. The bench compares every decimal add for both carry values and all operand pairs against a behavioural model. Strided sweeps cover binary add, binary subtract and decimal subtract.

// File: rtl/bcd_alu_pkg.sv
`timescale 1ns/1ps
package bcd_alu_pkg;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/bin_addsub.sv
`timescale 1ns/1ps
// Two's-complement adder with operand inversion for subtraction.
module bin_addsub #(
  parameter int WIDTH = 8
) (
  input  logic                     sub_i,
  input  logic                     cin_i,
  input  logic [WIDTH-1:0]         a_i,
  input  logic [WIDTH-1:0]         m_i,
  output logic [WIDTH-1:0]         sum_o,
  output bcd_alu_pkg::alu_flags_t  flags_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] m_eff;
  logic [WIDTH:0]   wide_sum;

  always_comb begin
    m_eff    = sub_i ? ~m_i : m_i;
    wide_sum = {1'b0, a_i} + {1'b0, m_eff} + {{WIDTH{1'b0}}, cin_i};
    sum_o    = wide_sum[MSB:0];
    flags_o.c = wide_sum[WIDTH];
    flags_o.n = wide_sum[MSB];
    flags_o.z = (wide_sum[MSB:0] == '0);
    flags_o.v = (a_i[MSB] ~^ m_eff[MSB]) & (a_i[MSB] ^ wide_sum[MSB]);
  end
endmodule

// File: rtl/bcd_digit.sv
`timescale 1ns/1ps
// One decimal digit slice: add-six / subtract-six correction with carry.
module bcd_digit (
  input  logic       sub_i,
  input  logic       cy_i,      // carry (add) or borrow (sub)
  input  logic [3:0] a_i,
  input  logic [3:0] m_i,
  output logic [3:0] q_o,
  output logic       cy_o,
  output logic       pre_msb_o  // bit 3 of the uncorrected add sum
);
  logic [4:0] sum5;
  logic [3:0] sum_fix;
  logic       add_over;
  logic [4:0] dif5;
  logic [3:0] dif_fix;
  logic       sub_neg;

  always_comb begin
    sum5     = {1'b0, a_i} + {1'b0, m_i} + {4'b0, cy_i};
    add_over = (sum5 >= 5'd10);
    sum_fix  = sum5[3:0] + 4'd6;
    dif5     = {1'b0, a_i} - {1'b0, m_i} - {4'b0, cy_i};
    sub_neg  = dif5[4];
    dif_fix  = dif5[3:0] - 4'd6;
    if (sub_i) begin
      q_o  = sub_neg ? dif_fix : dif5[3:0];
      cy_o = sub_neg;
    end else begin
      q_o  = add_over ? sum_fix : sum5[3:0];
      cy_o = add_over;
    end
    pre_msb_o = sum5[3];
  end
endmodule

// File: rtl/bcd_chain.sv
`timescale 1ns/1ps
// Ripple of decimal digit slices across the operand width.
module bcd_chain #(
  parameter int DIGITS = 2
) (
  input  logic                            sub_i,
  input  logic                            cin_i,
  input  logic [DIGITS*bcd_alu_pkg::DIGIT_W-1:0] a_i,
  input  logic [DIGITS*bcd_alu_pkg::DIGIT_W-1:0] m_i,
  output logic [DIGITS*bcd_alu_pkg::DIGIT_W-1:0] q_o,
  output logic                            cout_o,
  output logic                            pre_msb_o
);
  localparam int DW = bcd_alu_pkg::DIGIT_W;

  logic [DIGITS:0]   cy;
  logic [DIGITS-1:0] pre_msb;

  assign cy[0] = sub_i ? ~cin_i : cin_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    bcd_digit u_digit (
      .sub_i     (sub_i),
      .cy_i      (cy[k]),
      .a_i       (a_i[k*DW +: DW]),
      .m_i       (m_i[k*DW +: DW]),
      .q_o       (q_o[k*DW +: DW]),
      .cy_o      (cy[k+1]),
      .pre_msb_o (pre_msb[k])
    );
  end

  assign cout_o    = cy[DIGITS];
  assign pre_msb_o = pre_msb[DIGITS-1];

  if (DIGITS > 1) begin : g_low_pre
    logic unused_low_pre;
    assign unused_low_pre = ^pre_msb[DIGITS-2:0];
  end
endmodule

// File: rtl/bcd_addsub_alu.sv
`timescale 1ns/1ps
module bcd_addsub_alu #(
  parameter int DIGITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [DIGITS*4-1:0]   a,
  input  logic [DIGITS*4-1:0]   m,
  input  logic                  cin,
  input  logic                  dec,
  input  logic                  sub,
  output logic [DIGITS*4-1:0]   res,
  output logic                  flag_n,
  output logic                  flag_v,
  output logic                  flag_z,
  output logic                  flag_c
);
  import bcd_alu_pkg::*;

  localparam int WIDTH = DIGITS * DIGIT_W;
  localparam int MSB   = WIDTH - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // datapath
  logic [MSB:0] bin_sum;
  alu_flags_t   bin_flags;
  logic [MSB:0] dec_sum;
  logic         dec_cout;
  logic         dec_pre_msb;

  bin_addsub #(.WIDTH(WIDTH)) u_bin (
    .sub_i   (sub),
    .cin_i   (cin),
    .a_i     (a),
    .m_i     (m),
    .sum_o   (bin_sum),
    .flags_o (bin_flags)
  );

  bcd_chain #(.DIGITS(DIGITS)) u_dec (
    .sub_i     (sub),
    .cin_i     (cin),
    .a_i       (a),
    .m_i       (m),
    .q_o       (dec_sum),
    .cout_o    (dec_cout),
    .pre_msb_o (dec_pre_msb)
  );

  logic [MSB:0] calc_res;
  alu_flags_t   calc_flags;

  always_comb begin
    calc_res   = bin_sum;
    calc_flags = bin_flags;
    if (dec) begin
      calc_res = dec_sum;
      if (!sub) begin
        calc_flags.n = dec_pre_msb;
        calc_flags.v = (a[MSB] ~^ m[MSB]) & (a[MSB] ^ dec_pre_msb);
        calc_flags.c = dec_cout;
        calc_flags.z = bin_flags.z;
      end
    end
  end

  // output register with explicit enable
  logic [MSB:0] res_q, res_d;
  alu_flags_t   flags_q, flags_d;

  always_comb begin
    res_d   = res_q;
    flags_d = flags_q;
    if (go) begin
      res_d   = calc_res;
      flags_d = calc_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

  assign res    = res_q;
  assign flag_n = flags_q.n;
  assign flag_v = flags_q.v;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;

  // checks
  function automatic logic all_digits_ok(input logic [MSB:0] w);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (w[k*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  a_r7_hold_without_go: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !go |=> $stable({res, flag_n, flag_v, flag_z, flag_c}));

  a_r2_not_borrow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && sub) |=>
      (flag_c == ({1'b0, $past(a)} >= ({1'b0, $past(m)} + {{WIDTH{1'b0}}, !$past(cin)}))));

  a_r4_dec_zero_binary: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && dec && !sub) |=>
      (flag_z == ((($past(a) + $past(m) + {{MSB{1'b0}}, $past(cin)}) & {WIDTH{1'b1}}) == '0)));

  a_r1_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && !dec) |=> (flag_z == (res == '0)));

  a_r9_bcd_closed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && dec && !sub && all_digits_ok(a) && all_digits_ok(m)) |=> all_digits_ok(res));
endmodule

// File: tb/tb_bcd_addsub_alu.sv
`timescale 1ns/1ps
module tb_bcd_addsub_alu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       go;
  logic [7:0] a, m;
  logic       cin, dec, sub;
  logic [7:0] res;
  logic       flag_n, flag_v, flag_z, flag_c;

  bcd_addsub_alu dut (
    .clk(clk), .rst_n(rst_n), .go(go), .a(a), .m(m), .cin(cin),
    .dec(dec), .sub(sub), .res(res), .flag_n(flag_n), .flag_v(flag_v),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 1'b0;
  logic [11:0] expect_q = '0;   // {res, n, v, z, c}
  string pend_tag = "R8";

  // behavioural model: {res[7:0], n, v, z, c}
  function automatic logic [11:0] model(int ai, int mi, int ci, int di, int si);
    int mb, bs, br, al, t;
    logic bn, bv, bz, bc, rn, rv, rc;
    mb = si ? (~mi & 255) : mi;
    bs = ai + mb + ci;
    br = bs & 255;
    bn = br[7];
    bz = (br == 0);
    bc = (bs > 255);
    bv = ((~(ai ^ mb)) & (ai ^ bs) & 128) != 0;
    if (!di) return {br[7:0], bn, bv, bz, bc};
    if (si) begin
      al = (ai & 15) - (mi & 15) + ci - 1;
      if (al < 0) al = ((al - 6) & 15) - 16;
      t = (ai & 240) - (mi & 240) + al;
      if (t < 0) t = t - 96;
      t = t & 255;
      return {t[7:0], bn, bv, bz, bc};
    end
    al = (ai & 15) + (mi & 15) + ci;
    if (al >= 10) al = ((al + 6) & 15) + 16;
    t  = (ai & 240) + (mi & 240) + al;
    rn = t[7];
    rv = ((~(ai ^ mi)) & (ai ^ t) & 128) != 0;
    rc = 1'b0;
    if (t >= 160) begin
      t  = t + 96;
      rc = 1'b1;
    end
    t = t & 255;
    return {t[7:0], rn, rv, bz, rc};
  endfunction

  task automatic step(input int ai, input int mi, input int ci, input int di,
                      input int si, input bit g, input string tag);
    logic [11:0] got;
    @(negedge clk);
    got = {res, flag_n, flag_v, flag_z, flag_c};
    n_checks++;
    if (got !== expect_q) begin
      n_fail++;
      $display("FAIL %s: got res=%h nvzc=%b expected res=%h nvzc=%b",
               pend_tag, got[11:4], got[3:0], expect_q[11:4], expect_q[3:0]);
    end
    a   = ai[7:0];
    m   = mi[7:0];
    cin = ci[0];
    dec = di[0];
    sub = si[0];
    go  = g;
    if (g) expect_q = model(ai, mi, ci, di, si);
    pend_tag = tag;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 195000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; a = '0; m = '0; cin = 0; dec = 0; sub = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // first compare is the reset state (R8)
    step(8'h00, 8'h0F, 0, 1, 0, 1'b1, "R3");
    step(8'h00, 8'h1F, 0, 1, 0, 1'b1, "R3");
    step(8'h10, 8'h1F, 0, 1, 0, 1'b1, "R3");
    step(8'h05, 8'h1F, 0, 1, 0, 1'b1, "R3");
    step(8'h0F, 8'h0A, 0, 1, 0, 1'b1, "R3");
    step(8'h0F, 8'h0B, 0, 1, 0, 1'b1, "R3");
    step(8'h80, 8'h80, 0, 1, 0, 1'b1, "R4");
    step(8'h50, 8'h50, 0, 1, 0, 1'b1, "R5");
    step(8'h79, 8'h00, 1, 1, 0, 1'b1, "R5");
    step(8'h00, 8'h01, 1, 1, 1, 1'b1, "R6");
    step(8'h10, 8'h01, 1, 1, 1, 1'b1, "R6");
    step(8'h7F, 8'h01, 0, 0, 0, 1'b1, "R1");
    step(8'h40, 8'h41, 1, 0, 1, 1'b1, "R2");
    // R7: inputs toggle with go low; outputs must stay
    step(8'hFF, 8'hFF, 1, 1, 0, 1'b0, "R7");
    step(8'h12, 8'h34, 0, 0, 1, 1'b0, "R7");
    step(8'h99, 8'h99, 1, 1, 1, 1'b0, "R7");

    for (int i = 0; i < 512; i++)
      step(i & 255, (i * 73 + 19) & 255, i >> 8, 0, 0, 1'b1, "R1");
    for (int i = 0; i < 512; i++)
      step(i & 255, (i * 151 + 5) & 255, i >> 8, 0, 1, 1'b1, "R2");
    for (int i = 0; i < 8192; i++)
      step((i * 29 + 3) & 255, (i * 113 + 7) & 255, i & 1, 1, 1, 1'b1, "R6");

    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++) begin
          bit ok_digits;
          ok_digits = ((x & 15) < 10) && ((x >> 4) < 10) &&
                      ((y & 15) < 10) && ((y >> 4) < 10);
          step(x, y, c, 1, 0, 1'b1, ok_digits ? "R9" : "R5");
        end

    step(0, 0, 0, 0, 0, 1'b0, "R7");
    step(0, 0, 0, 0, 0, 1'b0, "R7");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule